// File: doc/BRIEF.md
# Margining Divider Control

This block is the digital control front end of a clock synthesizer whose output frequency can be moved away from nominal for margin testing. A three-wire serial port carries a six-bit feedback divider value. The port has a load strobe, a shift clock and a data line, and it is sampled in the system clock domain. While the load strobe is high, each rising edge of the shift clock moves one data bit into a shift register, most significant bit first. When the strobe falls, the shifted value is copied into a holding register.

A mode input picks the divider code sent to the PLL. When the mode input is low, the block sends a fixed nominal code of 50. With the 12.5 MHz pre-divided reference, that code gives a 625 MHz VCO and a 312.5 MHz output after the fixed divide-by-two. When the mode input is high, the held serial value is sent instead, and each unit step moves the output by 2%. Returning the mode input low restores the nominal code, and the held value is kept. The block also raises a flag when the code in effect would put the VCO outside its 560 to 690 MHz lock window. It passes the output-enable and reference-select controls through to the analog section.

Top module: `fmargin_ctrl`

## Requirements
- R1: While the synchronised load strobe is high, each rising edge of the shift clock shifts the data bit into the six-bit shift register at bit 0, and earlier bits move toward bit 5. After six edges, bit 5 holds the first bit sent.
- R2: While the load strobe is low, shift clock and data activity has no effect on the shift register.
- R3: A high-to-low transition of the load strobe copies the shift register into the holding register. The code in effect changes only at that transition and never during shifting.
- R4: With `margin_i` low, `fb_div_o` is 50 (binary 110010), whatever value is held.
- R5: With `margin_i` high, `fb_div_o` equals the held value. Leaving margining mode and entering it again shows the same held value.
- R6: A serial load done while `margin_i` is low is accepted, and it becomes visible when `margin_i` goes high.
- R7: After reset, the holding register contains 50, so margining mode gives 50 before any load.
- R8: `range_err_o` is 1 exactly when the code in effect times 12.5 MHz is below 560 MHz or above 690 MHz. That makes codes 45 to 55 the in-range codes.
- R9: `out_en_o` follows `oe_i`, where 1 enables the output pair and 0 makes it high-impedance. `ref_clk_sel_o` follows `ref_sel_i`, where 0 selects the crystal and 1 selects the clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_ld_i | input | 1 | Serial load strobe (asynchronous) |
| margin_i | input | 1 | 1 selects the held code, 0 selects the nominal code |
| oe_i | input | 1 | Output enable request |
| ref_sel_i | input | 1 | Reference source request |
| fb_div_o | output | 6 | Feedback divider code in effect |
| range_err_o | output | 1 | Code in effect lies outside the VCO window |
| out_en_o | output | 1 | Output buffer enable |
| ref_clk_sel_o | output | 1 | Reference source select |

## Verification
Each serial pin passes through two synchroniser flops and one edge-detect flop. A shift therefore lands on the third system clock edge after the pin changes, and a latch lands on the third edge after the strobe falls. The bench holds each serial level for at least three cycles and waits six cycles after the strobe falls before it samples. `fb_div_o`, `range_err_o` and the pass-through outputs are combinational from the mode input and the holding register, so the bench checks them one cycle after it changes the mode input. All sampling happens on the falling clock edge. The bench loads all 64 codes and compares the code in effect and the window flag against values it computes arithmetically.

// File: rtl/fmargin_ctrl.sv
module fmargin_ctrl #(
  parameter int W           = 6,
  parameter int NOM_CODE    = 50,
  parameter int REF_KHZ     = 12500,
  parameter int VCO_MIN_KHZ = 560000,
  parameter int VCO_MAX_KHZ = 690000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk_i,
  input  logic         ser_dat_i,
  input  logic         ser_ld_i,
  input  logic         margin_i,
  input  logic         oe_i,
  input  logic         ref_sel_i,
  output logic [W-1:0] fb_div_o,
  output logic         range_err_o,
  output logic         out_en_o,
  output logic         ref_clk_sel_o
);
  localparam logic [W-1:0] NOM    = W'(NOM_CODE);
  localparam int           LO_CODE = (VCO_MIN_KHZ + REF_KHZ - 1) / REF_KHZ;
  localparam int           HI_CODE = VCO_MAX_KHZ / REF_KHZ;

  logic [2:0]   sc_q, ld_q;
  logic [1:0]   dt_q;
  logic [W-1:0] shreg, held;
  logic [31:0]  vco_khz;

  wire ld_s      = ld_q[1];
  wire sclk_rise = sc_q[1] & ~sc_q[2];
  wire ld_fall   = ~ld_q[1] & ld_q[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sc_q <= '0;
      ld_q <= '0;
      dt_q <= '0;
    end else begin
      sc_q <= {sc_q[1:0], ser_clk_i};
      ld_q <= {ld_q[1:0], ser_ld_i};
      dt_q <= {dt_q[0], ser_dat_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 shreg <= NOM;
    else if (ld_s && sclk_rise) shreg <= {shreg[W-2:0], dt_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       held <= NOM;
    else if (ld_fall) held <= shreg;

  assign fb_div_o      = margin_i ? held : NOM;
  assign vco_khz       = 32'(fb_div_o) * 32'(REF_KHZ);
  assign range_err_o   = (vco_khz < 32'(VCO_MIN_KHZ)) || (vco_khz > 32'(VCO_MAX_KHZ));
  assign out_en_o      = oe_i;
  assign ref_clk_sel_o = ref_sel_i;

  // R1
  shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s && sclk_rise) |=> (shreg[0] == $past(dt_q[1])) && (shreg[W-1:1] == $past(shreg[W-2:0])));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_s |=> $stable(shreg));

  // R3
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fall |=> held == $past(shreg));

  // R8
  window_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fb_div_o) >= LO_CODE && int'(fb_div_o) <= HI_CODE) |-> !range_err_o);
endmodule

// File: tb/fmargin_ctrl_tb_top.sv
module fmargin_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdat = 0, sld = 0, margin = 0, oe = 0, rsel = 0;
  logic [5:0] fb;
  logic rerr, oen, rcs;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fmargin_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .margin_i(margin), .oe_i(oe), .ref_sel_i(rsel),
    .fb_div_o(fb), .range_err_o(rerr), .out_en_o(oen), .ref_clk_sel_o(rcs));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    @(negedge clk);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [5:0] v);
    for (int i = 5; i >= 0; i--) begin
      sdat = v[i]; tick(3);
      sclk = 1;    tick(4);
      sclk = 0;    tick(3);
    end
  endtask

  task automatic load(input logic [5:0] v);
    sld = 1; tick(4);
    shift_bits(v);
    sld = 0; tick(6);
  endtask

  function automatic int exp_err(input int c);
    return (c * 12500 < 560000 || c * 12500 > 690000) ? 1 : 0;
  endfunction

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog got=0 exp=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    join_none
    tick(3); rst_n = 1; tick(2);
    // R7 reset state, R4 default
    chk("R4", fb, 50);
    chk("R8", rerr, 0);
    margin = 1; tick(1);
    chk("R7", fb, 50);
    // R9 pass-through
    for (int k = 0; k < 4; k++) begin
      oe = k[0]; rsel = k[1]; tick(1);
      chk("R9", oen, k & 1);
      chk("R9", rcs, (k >> 1) & 1);
    end
    // R1/R5/R8 exhaustive sweep in margining mode
    for (int c = 0; c < 64; c++) begin
      load(6'(c));
      chk("R1", fb, c);
      chk("R8", rerr, exp_err(c));
    end
    // R3 no change while shifting
    load(6'd47);
    sld = 1; tick(4); shift_bits(6'd53);
    chk("R3", fb, 47);
    sld = 0; tick(6);
    chk("R3", fb, 53);
    // R2 activity with load low ignored
    for (int i = 0; i < 6; i++) begin
      sdat = ~sdat; tick(3); sclk = 1; tick(4); sclk = 0; tick(3);
    end
    sld = 1; tick(6); sld = 0; tick(6);
    chk("R2", fb, 53);
    // R4 / R5 mode round trip
    margin = 0; tick(1);
    chk("R4", fb, 50);
    chk("R8", rerr, 0);
    margin = 1; tick(1);
    chk("R5", fb, 53);
    // R6 load in default mode
    margin = 0; tick(1);
    load(6'd45);
    chk("R6", fb, 50);
    margin = 1; tick(1);
    chk("R6", fb, 45);
    chk("R8", rerr, 0);
    load(6'd44);
    chk("R8", rerr, 1);
    load(6'd56);
    chk("R8", rerr, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule